// File: doc/BRIEF.md
# Lockable Identification Page Controller

This block holds a 128-byte identification page next to a main memory array. A two-wire bus engine, which is outside the block, turns bus traffic into byte events. The block decodes the command bytes that carry the identification device type. It chooses between a page write and a permanent lock from one address bit. It stages written bytes and commits them when a Stop arrives. It serves random, current-address and sequential reads from the page. For every byte it receives, it returns an ACK/NoACK decision to the engine.

The lock is a one-way flag. A lock command whose data byte has the lock bit set, followed by a Stop, makes the page read-only for good. Only a power-on reset clears the flag, and that reset stands in for nonvolatile retention. The host can ask whether the page is locked by sending a lock command and reading the ACK of its data byte. It then cancels the command with Start followed by Stop.

The interfaces carry no back-pressure. The block accepts every byte that arrives with `rx_valid`, and it gives exactly one `ack_valid` pulse one clock later. A `rd_req` pulse during the read phase acts as the ready for the next outgoing byte, and `tx_valid` with `tx_byte` answers it one clock later. `bus_start` and `bus_stop` take priority over a byte in the same cycle. The engine never issues them together with `rx_valid` or `rd_req`.

Top module: `idp_ctrl`

## Requirements
- R1: A select byte is acknowledged only when its upper nibble is 1011 and bits 3..1 equal `dev_addr`. Any other select byte, including a 1010 main-array select, gets NoACK. Every byte after it gets NoACK and has no effect until the next Start.
- R2: After a write select, the first address byte has bit 2 (address bit 10) equal to 0, and the low seven bits of the second address byte give the start offset. All other address bits are ignored. Data bytes are acknowledged and placed at successive offsets, and the offset wraps from 127 to 0.
- R3: Written bytes reach the page only when a Stop ends the write. A Start that arrives before the Stop discards them, and the page keeps its old contents.
- R4: A lock command has address bit 10 equal to 1. A Stop after it sets the lock only if an acknowledged data byte had bit 1 set. A data byte with bit 1 clear leaves the page unlocked, and the other data bits are ignored.
- R5: The ACK of the lock command's data byte gives the lock status: ACK while unlocked, NoACK once locked. A Start followed by a Stop after that byte leaves the lock unchanged.
- R6: Once the page is locked, it stays locked until power-on reset. Data bytes of an identification write get NoACK and the page is not changed.
- R7: While `wp` is high, data bytes of both identification writes and lock commands get NoACK and change neither the page nor the lock.
- R8: A read select, after an optional dummy write that loads the offset, opens the read phase. Each `rd_req` gives `tx_valid` one cycle later with the byte at the current offset, and the offset then advances and wraps from 127 to 0. A read with no dummy write continues from the offset the last access left.
- R9: Every byte taken with `rx_valid` gets one `ack_valid` pulse in the next cycle, and `ack_valid` never rises without a byte. Both address bytes of a write select are always acknowledged.
- R10: After reset, the page reads 0xFF at every offset, and `locked`, `ack_valid` and `tx_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low power-on reset; the only way to clear the lock |
| dev_addr | input | 3 | Chip address strapped on the board, compared with select bits 3..1 |
| wp | input | 1 | Write protect; blocks identification writes and locking |
| bus_start | input | 1 | One-cycle pulse: the engine saw a Start |
| bus_stop | input | 1 | One-cycle pulse: the engine saw a Stop |
| rx_valid | input | 1 | A byte from the host is present on rx_byte |
| rx_byte | input | 8 | Byte received from the host |
| ack_valid | output | 1 | The ACK decision for the previous byte is valid |
| ack | output | 1 | 1 = ACK, 0 = NoACK |
| rd_req | input | 1 | Engine asks for the next read byte |
| tx_valid | output | 1 | tx_byte holds the requested read byte |
| tx_byte | output | 8 | Byte to send to the host |
| locked | output | 1 | The identification page is permanently locked |

## Verification
The bound checker watches four properties on every cycle: each received byte gets exactly one ACK decision on the next cycle, a read request in the read phase is answered one cycle later, the lock never falls, and the lock rises only on the cycle after a Stop. Effects on the data are left to the bench: offsets wrapping inside the page, writes discarded by an early Start, the lock-status answer, and NoACK with an unchanged page under the lock or write protect. The bench shows these by reading the page back through the normal read protocol after each transaction.

// File: rtl/idp_pkg.sv
package idp_pkg;

  localparam int unsigned IDP_PAGE_BYTES = 128;
  localparam logic [3:0]  IDP_DEV_TYPE   = 4'b1011;
  localparam int unsigned IDP_LOCK_ABIT  = 10;
  localparam int unsigned IDP_LOCK_DBIT  = 1;
  localparam logic [7:0]  IDP_ERASED     = 8'hFF;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEL,
    ST_AHI,
    ST_ALO,
    ST_WDATA,
    ST_LDATA,
    ST_RDATA,
    ST_SKIP
  } idp_state_e;

endpackage

// File: rtl/idp_cmd.sv
module idp_cmd
  import idp_pkg::*;
#(
  parameter int unsigned OFS_W     = 7,
  parameter logic [3:0]  DEV_TYPE  = IDP_DEV_TYPE,
  parameter int unsigned LOCK_ABIT = IDP_LOCK_ABIT,
  parameter int unsigned LOCK_DBIT = IDP_LOCK_DBIT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       dev_addr,
  input  logic             wp,
  input  logic             locked,
  input  logic             bus_start,
  input  logic             bus_stop,
  input  logic             rx_valid,
  input  logic [7:0]       rx_byte,
  input  logic             rd_req,
  output logic             ack_valid,
  output logic             ack,
  output logic             stg_we,
  output logic [OFS_W-1:0] ofs,
  output logic             commit,
  output logic             stage_clr,
  output logic             lock_set,
  output logic             rd_fire,
  output logic             rd_phase
);

  localparam int unsigned HI_BIT = LOCK_ABIT - 8;
  localparam logic [OFS_W-1:0] OFS_ONE = {{(OFS_W-1){1'b0}}, 1'b1};

  idp_state_e       st_q, st_nxt;
  logic [OFS_W-1:0] ptr_q;
  logic             a10_q;
  logic             lock_req_q;
  logic             ack_nxt;
  logic             ptr_load;
  logic             data_ok;
  logic             sel_hit;
  logic             byte_evt;

  assign data_ok  = !locked && !wp;
  assign sel_hit  = (rx_byte[7:4] == DEV_TYPE) && (rx_byte[3:1] == dev_addr);
  assign byte_evt = rx_valid && !bus_start && !bus_stop;

  always_comb begin
    st_nxt   = st_q;
    ack_nxt  = 1'b0;
    ptr_load = 1'b0;
    unique case (st_q)
      ST_SEL: begin
        ack_nxt = sel_hit;
        if (!sel_hit)        st_nxt = ST_SKIP;
        else if (rx_byte[0]) st_nxt = ST_RDATA;
        else                 st_nxt = ST_AHI;
      end
      ST_AHI: begin
        ack_nxt = 1'b1;
        st_nxt  = ST_ALO;
      end
      ST_ALO: begin
        ack_nxt  = 1'b1;
        ptr_load = 1'b1;
        st_nxt   = a10_q ? ST_LDATA : ST_WDATA;
      end
      ST_WDATA: ack_nxt = data_ok;
      ST_LDATA: ack_nxt = data_ok;
      default:  ack_nxt = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      ptr_q      <= '0;
      a10_q      <= 1'b0;
      lock_req_q <= 1'b0;
      ack_valid  <= 1'b0;
      ack        <= 1'b0;
    end else begin
      ack_valid <= 1'b0;
      ack       <= 1'b0;
      if (bus_start) begin
        st_q       <= ST_SEL;
        lock_req_q <= 1'b0;
      end else if (bus_stop) begin
        st_q       <= ST_IDLE;
        lock_req_q <= 1'b0;
      end else begin
        if (rx_valid) begin
          ack_valid <= 1'b1;
          ack       <= ack_nxt;
          st_q      <= st_nxt;
          if (st_q == ST_AHI) a10_q <= rx_byte[HI_BIT];
          if (ptr_load) ptr_q <= rx_byte[OFS_W-1:0];
          else if (st_q == ST_WDATA && data_ok) ptr_q <= ptr_q + OFS_ONE;
          if (st_q == ST_LDATA && data_ok && rx_byte[LOCK_DBIT]) lock_req_q <= 1'b1;
        end
        if (rd_fire) ptr_q <= ptr_q + OFS_ONE;
      end
    end
  end

  assign ofs       = ptr_q;
  assign stg_we    = byte_evt && (st_q == ST_WDATA) && data_ok;
  assign commit    = bus_stop && !bus_start && (st_q == ST_WDATA);
  assign stage_clr = bus_start || bus_stop;
  assign lock_set  = bus_stop && !bus_start && (st_q == ST_LDATA) && lock_req_q;
  assign rd_phase  = (st_q == ST_RDATA);
  assign rd_fire   = rd_req && rd_phase && !bus_start && !bus_stop;

endmodule

// File: rtl/idp_page.sv
module idp_page
  import idp_pkg::*;
#(
  parameter int unsigned DEPTH  = IDP_PAGE_BYTES,
  parameter int unsigned OFS_W  = 7,
  parameter logic [7:0]  ERASED = IDP_ERASED
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stg_we,
  input  logic [OFS_W-1:0] ofs,
  input  logic [7:0]       stg_data,
  input  logic             commit,
  input  logic             stage_clr,
  input  logic             rd_fire,
  output logic             tx_valid,
  output logic [7:0]       tx_byte
);

  logic [DEPTH*8-1:0] page_flat;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    logic [7:0] stg_q;
    logic       msk_q;
    logic [7:0] mem_q;
    logic       hit;

    assign hit = stg_we && (ofs == OFS_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stg_q <= '0;
        msk_q <= 1'b0;
        mem_q <= ERASED;
      end else begin
        if (hit) begin
          stg_q <= stg_data;
          msk_q <= 1'b1;
        end else if (stage_clr) begin
          msk_q <= 1'b0;
        end
        if (commit && msk_q) mem_q <= stg_q;
      end
    end

    assign page_flat[g*8 +: 8] = mem_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_byte  <= '0;
    end else begin
      tx_valid <= rd_fire;
      if (rd_fire) tx_byte <= page_flat[ofs*8 +: 8];
    end
  end

endmodule

// File: rtl/idp_lock.sv
module idp_lock (
  input  logic clk,
  input  logic rst_n,
  input  logic lock_set,
  output logic locked
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        locked <= 1'b0;
    else if (lock_set) locked <= 1'b1;
  end

endmodule

// File: rtl/idp_ctrl.sv
module idp_ctrl
  import idp_pkg::*;
#(
  parameter int unsigned PAGE_BYTES = IDP_PAGE_BYTES,
  parameter logic [3:0]  DEV_TYPE   = IDP_DEV_TYPE,
  parameter int unsigned LOCK_ABIT  = IDP_LOCK_ABIT,
  parameter int unsigned LOCK_DBIT  = IDP_LOCK_DBIT
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] dev_addr,
  input  logic       wp,
  input  logic       bus_start,
  input  logic       bus_stop,
  input  logic       rx_valid,
  input  logic [7:0] rx_byte,
  output logic       ack_valid,
  output logic       ack,
  input  logic       rd_req,
  output logic       tx_valid,
  output logic [7:0] tx_byte,
  output logic       locked
);

  localparam int unsigned OFS_W = $clog2(PAGE_BYTES);

  logic             stg_we;
  logic [OFS_W-1:0] ofs;
  logic             commit;
  logic             stage_clr;
  logic             lock_set;
  logic             rd_fire;
  logic             rd_phase;

  idp_cmd #(
    .OFS_W     (OFS_W),
    .DEV_TYPE  (DEV_TYPE),
    .LOCK_ABIT (LOCK_ABIT),
    .LOCK_DBIT (LOCK_DBIT)
  ) u_cmd (
    .clk       (clk),
    .rst_n     (rst_n),
    .dev_addr  (dev_addr),
    .wp        (wp),
    .locked    (locked),
    .bus_start (bus_start),
    .bus_stop  (bus_stop),
    .rx_valid  (rx_valid),
    .rx_byte   (rx_byte),
    .rd_req    (rd_req),
    .ack_valid (ack_valid),
    .ack       (ack),
    .stg_we    (stg_we),
    .ofs       (ofs),
    .commit    (commit),
    .stage_clr (stage_clr),
    .lock_set  (lock_set),
    .rd_fire   (rd_fire),
    .rd_phase  (rd_phase)
  );

  idp_page #(
    .DEPTH (PAGE_BYTES),
    .OFS_W (OFS_W)
  ) u_page (
    .clk       (clk),
    .rst_n     (rst_n),
    .stg_we    (stg_we),
    .ofs       (ofs),
    .stg_data  (rx_byte),
    .commit    (commit),
    .stage_clr (stage_clr),
    .rd_fire   (rd_fire),
    .tx_valid  (tx_valid),
    .tx_byte   (tx_byte)
  );

  idp_lock u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .lock_set (lock_set),
    .locked   (locked)
  );

endmodule

// File: rtl/idp_ctrl_chk.sv
module idp_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic bus_start,
  input logic bus_stop,
  input logic rx_valid,
  input logic ack_valid,
  input logic rd_req,
  input logic rd_phase,
  input logic tx_valid,
  input logic locked
);

  // R9
  ack_follows_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !bus_start && !bus_stop) |=> ack_valid);

  // R9
  no_stray_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> !ack_valid);

  // R8
  read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_phase && !bus_start && !bus_stop) |=> tx_valid);

  // R6
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);

  // R4
  lock_on_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(bus_stop));

endmodule

bind idp_ctrl idp_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_start (bus_start),
  .bus_stop  (bus_stop),
  .rx_valid  (rx_valid),
  .ack_valid (ack_valid),
  .rd_req    (rd_req),
  .rd_phase  (rd_phase),
  .tx_valid  (tx_valid),
  .locked    (locked)
);

// File: tb/idp_ctrl_tb.sv
module idp_ctrl_tb;

  localparam logic [2:0] DEV = 3'b101;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] dev_addr = DEV;
  logic       wp = 1'b0;
  logic       bus_start = 1'b0;
  logic       bus_stop = 1'b0;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_byte = '0;
  logic       ack_valid;
  logic       ack;
  logic       rd_req = 1'b0;
  logic       tx_valid;
  logic [7:0] tx_byte;
  logic       locked;

  int unsigned n_chk = 0;
  int unsigned n_fail = 0;

  logic [7:0] exp_page [128];
  logic [6:0] exp_ptr = '0;
  logic       exp_locked = 1'b0;
  logic [7:0] stage_d [128];
  logic       stage_m [128];

  always #5 clk = ~clk;

  idp_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .dev_addr(dev_addr), .wp(wp),
    .bus_start(bus_start), .bus_stop(bus_stop), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .ack_valid(ack_valid), .ack(ack), .rd_req(rd_req),
    .tx_valid(tx_valid), .tx_byte(tx_byte), .locked(locked)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  function automatic logic [7:0] sel_byte(input logic [3:0] typ, input logic [2:0] a, input logic rd);
    return {typ, a, rd};
  endfunction

  task automatic do_start();
    @(negedge clk) bus_start = 1'b1;
    @(negedge clk) bus_start = 1'b0;
  endtask

  task automatic do_stop();
    @(negedge clk) bus_stop = 1'b1;
    @(negedge clk) bus_stop = 1'b0;
  endtask

  // sends one byte; R9: the decision must be valid on the following cycle
  task automatic send(input string req, input logic [7:0] b, input logic exp_ack);
    @(negedge clk);
    rx_valid = 1'b1;
    rx_byte  = b;
    @(negedge clk);
    rx_valid = 1'b0;
    chk("R9 ack_valid", {31'b0, ack_valid}, 32'd1);
    chk(req, {31'b0, ack}, {31'b0, exp_ack});
  endtask

  task automatic id_write(input logic [6:0] ofs, input int n, input logic abort);
    logic [6:0] p;
    logic       ok;
    logic [7:0] d;
    for (int i = 0; i < 128; i++) stage_m[i] = 1'b0;
    do_start();
    send("R1 write select", sel_byte(4'b1011, DEV, 1'b0), 1'b1);
    send("R9 addr hi", 8'($urandom) & 8'hFB, 1'b1);
    send("R9 addr lo", {1'($urandom), ofs}, 1'b1);
    p  = ofs;
    ok = !exp_locked && !wp;
    for (int i = 0; i < n; i++) begin
      d = 8'($urandom);
      send(ok ? "R2 write data ack" : (exp_locked ? "R6 locked write nack" : "R7 wp write nack"), d, ok);
      if (ok) begin
        stage_d[p] = d;
        stage_m[p] = 1'b1;
        p = p + 7'd1;
      end
    end
    if (abort) do_start();
    do_stop();
    if (!abort)
      for (int i = 0; i < 128; i++) if (stage_m[i]) exp_page[i] = stage_d[i];
    exp_ptr = p;
  endtask

  task automatic id_read(input logic dummy, input logic [6:0] ofs, input int n, input string req);
    do_start();
    if (dummy) begin
      send("R1 dummy select", sel_byte(4'b1011, DEV, 1'b0), 1'b1);
      send("R8 addr hi any", 8'($urandom), 1'b1);
      send("R8 addr lo", {1'($urandom), ofs}, 1'b1);
      exp_ptr = ofs;
      do_start();
    end
    send("R1 read select", sel_byte(4'b1011, DEV, 1'b1), 1'b1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) rd_req = 1'b1;
      @(negedge clk) rd_req = 1'b0;
      chk("R8 tx_valid", {31'b0, tx_valid}, 32'd1);
      chk(req, {24'b0, tx_byte}, {24'b0, exp_page[exp_ptr]});
      exp_ptr = exp_ptr + 7'd1;
    end
    do_stop();
  endtask

  task automatic id_lock(input logic [7:0] d, input logic finish, input string req);
    logic [6:0] lo;
    logic       ok;
    lo = 7'($urandom);
    do_start();
    send("R1 lock select", sel_byte(4'b1011, DEV, 1'b0), 1'b1);
    send("R4 addr hi a10", 8'($urandom) | 8'h04, 1'b1);
    send("R4 addr lo", {1'b0, lo}, 1'b1);
    exp_ptr = lo;
    ok = !exp_locked && !wp;
    send(req, d, ok);
    if (!finish) do_start();
    do_stop();
    if (finish && ok && d[1]) exp_locked = 1'b1;
    @(negedge clk);
    chk("R4/R5 locked flag", {31'b0, locked}, {31'b0, exp_locked});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    summary();
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240611);
    for (int i = 0; i < 128; i++) exp_page[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 locked", {31'b0, locked}, 32'd0);
    chk("R10 ack_valid", {31'b0, ack_valid}, 32'd0);
    chk("R10 tx_valid", {31'b0, tx_valid}, 32'd0);
    id_read(1'b1, 7'd120, 10, "R10 erased read");

    // R1 foreign selects
    do_start();
    send("R1 main array select", sel_byte(4'b1010, DEV, 1'b0), 1'b0);
    send("R1 skip byte", 8'h00, 1'b0);
    send("R1 skip byte 2", 8'h5A, 1'b0);
    do_stop();
    do_start();
    send("R1 wrong chip", sel_byte(4'b1011, 3'b010, 1'b0), 1'b0);
    do_stop();
    id_read(1'b1, 7'd0, 4, "R1 page untouched");

    // R2 wrap within page
    id_write(7'd122, 12, 1'b0);
    id_read(1'b1, 7'd120, 16, "R2 wrapped write");

    // R3 aborted write
    id_write(7'd40, 6, 1'b1);
    id_read(1'b1, 7'd38, 10, "R3 abort keeps page");

    // random traffic
    for (int k = 0; k < 20; k++) begin
      id_write(7'($urandom), 1 + int'($urandom % 20), 1'b0);
      id_read(1'b1, 7'($urandom), 1 + int'($urandom % 12), "R2 random readback");
    end

    // R8 current address continues, with wrap across 127
    id_read(1'b1, 7'd125, 2, "R8 random read");
    id_read(1'b0, 7'd0, 5, "R8 current address read");

    // R7 write protect
    wp = 1'b1;
    id_write(7'd10, 4, 1'b0);
    id_lock(8'hFF, 1'b1, "R7 wp lock nack");
    wp = 1'b0;
    id_read(1'b1, 7'd8, 8, "R7 page unchanged");

    // R4 bit 1 clear does not lock
    id_lock(8'hFD, 1'b1, "R4 lock data ack");
    // R5 status query, cancelled by start+stop
    id_lock(8'h02, 1'b0, "R5 unlocked query ack");
    // R4 real lock
    id_lock(8'h02 | 8'($urandom), 1'b1, "R4 lock accepted");
    // R5 query once locked
    id_lock(8'h02, 1'b0, "R5 locked query nack");
    // R6 writes refused
    id_write(7'd60, 5, 1'b0);
    id_read(1'b1, 7'd58, 9, "R6 page unchanged");
    id_lock(8'h00, 1'b1, "R6 lock stays");

    summary();
    $finish;
  end

endmodule